// File: doc/BRIEF.md
# Periodic Interrupt Catch-Up Pacer

The pacer sits between a periodic tick source and one input of an interrupt controller. Every tick is counted in a backlog of expirations that have not yet been handed to the consumer. The pacer then releases them as interrupt request pulses, one at a time. It sends the next pulse only once the consumer has acknowledged the previous one, or once a fixed number of clock cycles has passed since the last pulse without an acknowledge.

The acknowledge input stands for the whole acceptance decision on the consumer side, including vector and mask checks. Each accepted acknowledge retires one backlog entry. A reload strobe, raised when the tick source is given a new period, throws away the whole backlog. The backlog count is visible at all times. When it reaches its largest value it holds there instead of wrapping.

Top module: `irq_catchup_pacer`

## Requirements
- R1: After reset, `irq_o` is 0 and `pending_o` is 0, and the pacer is armed, so the first tick produces a pulse without any acknowledge.
- R2: A tick in a cycle where neither an accepted acknowledge nor a reload occurs raises `pending_o` by one at the next clock edge.
- R3: When `pending_o` holds its largest value (2^CNT_W-1), a further tick leaves it at that value.
- R4: `irq_o` is raised only in the cycle after one in which `pending_o` was nonzero and the pacer was either armed or timed out.
- R5: `irq_o` lasts exactly one cycle, and two pulses are always separated by at least one low cycle.
- R6: A pulse disarms the pacer. No further pulse follows until an accepted acknowledge or the timeout.
- R7: An acknowledge while `pending_o` is nonzero lowers it by one at the next edge and rearms the pacer.
- R8: An acknowledge while `pending_o` is 0 is ignored: `pending_o` stays 0 and no pulse results.
- R9: Without an acknowledge, and with backlog remaining, a new pulse starts TIMEOUT_CYC+1 cycles after the previous pulse.
- R10: A reload clears `pending_o` to 0 at the next edge, overriding a tick or acknowledge in the same cycle.
- R11: A tick and an accepted acknowledge in the same cycle leave `pending_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle expiry strobe from the tick source |
| ack_i | input | 1 | Consumer accepted the interrupt |
| reload_i | input | 1 | Tick period reprogrammed; discards backlog |
| irq_o | output | 1 | One-cycle interrupt request pulse |
| pending_o | output | CNT_W | Undelivered expiration count |

## Verification
Four properties are checked on every cycle: a pulse never lasts more than one cycle, a pulse only follows a nonzero backlog, a reload always empties the backlog, and a saturated backlog holds its value. The bench's scenarios are needed for the rest. These are the exact spacing of timeout-driven reissues, rearming by acknowledge, acknowledges at zero being ignored, tick and acknowledge cancelling in the same cycle, and reload taking priority over simultaneous inputs.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_INC  = 2'd1,
    CNT_DEC  = 2'd2,
    CNT_CLR  = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/pacer_backlog.sv
module pacer_backlog
  import pacer_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cnt_op_e          op_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             nz_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    unique case (op_i)
      CNT_INC:  if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      CNT_DEC:  if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
      CNT_CLR:  cnt_d = '0;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign nz_o  = (cnt_q != '0);

  // R3
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_MAX && op_i == CNT_INC) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/pacer_timeout.sv
module pacer_timeout #(
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic expired_o
);
  localparam int unsigned EW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [EW-1:0] LIMIT = EW'(TIMEOUT_CYC);

  logic [EW-1:0] elapsed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 elapsed_q <= '0;
    else if (restart_i)          elapsed_q <= '0;
    else if (elapsed_q != LIMIT) elapsed_q <= elapsed_q + 1'b1;
  end

  assign expired_o = (elapsed_q == LIMIT);
endmodule

// File: rtl/pacer_issue.sv
module pacer_issue (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_nz_i,
  input  logic ack_i,
  input  logic expired_i,
  output logic issue_o,
  output logic irq_o
);
  logic ready_q, irq_q;
  logic ack_ok;

  assign ack_ok  = ack_i && pend_nz_i;
  // pulses never abut: a new issue waits one cycle after irq
  assign issue_o = pend_nz_i && (ready_q || expired_i) && !irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= issue_o;
      if (ack_ok)       ready_q <= 1'b1;
      else if (issue_o) ready_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;

  // R5
  one_cycle_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
endmodule

// File: rtl/irq_catchup_pacer.sv
module irq_catchup_pacer
  import pacer_pkg::*;
#(
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned TIMEOUT_CYC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ack_i,
  input  logic             reload_i,
  output logic             irq_o,
  output logic [CNT_W-1:0] pending_o
);
  cnt_op_e op;
  logic    pend_nz, expired, issue;
  logic    ack_ok;

  assign ack_ok = ack_i && pend_nz;

  always_comb begin
    if (reload_i)              op = CNT_CLR;
    else if (tick_i && !ack_ok) op = CNT_INC;
    else if (ack_ok && !tick_i) op = CNT_DEC;
    else                        op = CNT_HOLD;
  end

  pacer_backlog #(.CNT_W(CNT_W)) u_backlog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .cnt_o  (pending_o),
    .nz_o   (pend_nz)
  );

  pacer_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timeout (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (issue),
    .expired_o (expired)
  );

  pacer_issue u_issue (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pend_nz_i (pend_nz),
    .ack_i     (ack_i),
    .expired_i (expired),
    .issue_o   (issue),
    .irq_o     (irq_o)
  );

  // R4
  irq_needs_backlog_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(pending_o != '0));

  // R10
  reload_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> pending_o == '0);
endmodule

// File: tb/tb_irq_catchup_pacer.sv
`timescale 1ns/1ps
module tb_irq_catchup_pacer;
  localparam int CNT_W = 4;
  localparam int TO    = 16;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, ack = 1'b0, reload = 1'b0;
  logic irq;
  logic [CNT_W-1:0] pend;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_catchup_pacer #(.CNT_W(CNT_W), .TIMEOUT_CYC(TO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ack_i(ack),
    .reload_i(reload), .irq_o(irq), .pending_o(pend)
  );

  typedef struct {
    logic  e_irq;
    int    e_pend;
    string tag;
  } exp_t;
  exp_t sb[$];

  // requirement-level reference state
  int m_pend = 0, m_el = 0;
  bit m_ready = 1, m_irq = 0;

  task automatic step(input bit t, input bit a, input bit r, input string tag);
    bit issue, aok;
    exp_t e;
    @(negedge clk);
    tick = t; ack = a; reload = r;
    aok   = a && (m_pend != 0);
    issue = (m_pend != 0) && (m_ready || m_el == TO) && !m_irq;
    if (r)              m_pend = 0;
    else if (t && !aok) m_pend = (m_pend == MAXV) ? MAXV : m_pend + 1;
    else if (aok && !t) m_pend = m_pend - 1;
    if (aok)        m_ready = 1;
    else if (issue) m_ready = 0;
    if (issue)        m_el = 0;
    else if (m_el != TO) m_el = m_el + 1;
    m_irq = issue;
    e.e_irq = m_irq; e.e_pend = m_pend; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, tag);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (sb.size() != 0) begin
        e = sb.pop_front();
        checks++;
        if (irq !== e.e_irq) begin
          errors++;
          $display("FAIL %s irq_o actual=%0b expected=%0b", e.tag, irq, e.e_irq);
        end
        checks++;
        if (int'(pend) != e.e_pend) begin
          errors++;
          $display("FAIL %s pending_o actual=%0d expected=%0d", e.tag, pend, e.e_pend);
        end
      end
    end
  end

  initial begin : watchdog
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    checks++;
    if (irq !== 1'b0 || pend !== '0) begin
      errors++;
      $display("FAIL R1 reset irq=%0b pend=%0d expected irq=0 pend=0", irq, pend);
    end
    idle(2, "R1");
    // R1/R2/R4: single tick pulses immediately
    step(1, 0, 0, "R2");
    idle(4, "R4");
    // R7: ack retires entry
    step(0, 1, 0, "R7");
    idle(3, "R8");
    // R8: acks at zero ignored
    step(0, 1, 0, "R8");
    step(0, 1, 0, "R8");
    idle(3, "R8");
    // R6/R9: backlog without ack, timeout reissues
    for (int i = 0; i < 5; i++) step(1, 0, 0, "R2");
    idle(3 * (TO + 1) + 4, "R9");
    // R7: paced acks rearm
    for (int i = 0; i < 3; i++) begin
      step(0, 1, 0, "R7");
      idle(4, "R6");
    end
    // R5: ack right when pulse appears
    step(1, 0, 0, "R5");
    step(1, 0, 0, "R5");
    for (int i = 0; i < 8; i++) step(0, 1, 0, "R5");
    idle(4, "R5");
    // R3: saturation
    for (int i = 0; i < MAXV + 5; i++) step(1, 0, 0, "R3");
    idle(2, "R3");
    // R11: tick and ack cancel
    step(1, 1, 0, "R11");
    step(1, 1, 0, "R11");
    idle(2, "R11");
    // R10: reload beats tick and ack
    step(1, 0, 1, "R10");
    idle(3, "R10");
    for (int i = 0; i < 4; i++) step(1, 0, 0, "R2");
    step(1, 1, 1, "R10");
    idle(TO + 4, "R10");
    // R9 again from a fresh backlog
    for (int i = 0; i < 3; i++) step(1, 0, 0, "R9");
    idle(2 * (TO + 1) + 3, "R9");
    @(negedge clk);
    tick = 0; ack = 0; reload = 0;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule